// File: doc/BRIEF.md
# Interrupt Source Stage with Edge and Level Tracking

This block sits between a bank of interrupt request lines and the per-processor presentation controllers. Each line belongs to one of two kinds, fixed when the block is built. An edge source fires once for each rising edge. A level source stays active for as long as its line is held high. Every source holds the number of its target server, an 8-bit priority and a stored copy of a saved priority. Software sets these through a one-cycle configuration write. A priority of 0xFF masks the source.

Deliveries leave through a single valid/ready port as a record of (server, global number, priority). The global number is the source index plus a fixed base offset. A presentation controller may later send back a reject, an end-of-interrupt (EOI) or a resend request. The block keeps per-source status bits so that a rejected or masked event comes back later instead of being dropped. Those bits are: line asserted, delivery in flight, rejected, and masked while pending. A resend request walks every source, one per clock.

Top module: `isc_source_ctl`

## Requirements
- R1: A source whose priority is 0xFF produces no delivery, whatever its line, resend or reject activity.
- R2: On a rising edge of an unmasked edge source (LEVEL_MAP bit 0) there is exactly one delivery, carrying that source's server, number OFFSET+index and priority.
- R3: A rising edge on a masked edge source is remembered. A later configuration write that gives it a priority other than 0xFF produces exactly one delivery and clears the memory.
- R4: A level source (LEVEL_MAP bit 1) delivers when its line is high, it is unmasked and it has no delivery in flight. It then counts as in flight, and no further delivery occurs until that state is cleared and a line change, configuration write or resend re-evaluates it. A line that has gone low gives no delivery.
- R5: After a reject, an edge source is delivered again by the next resend exactly once. A level source whose line is still high is delivered again by the next resend.
- R6: A resend request scans the sources from index 0 upward, one per cycle. A new request during a scan restarts it at index 0.
- R7: An EOI clears the in-flight state of a level source but does not deliver by itself. An EOI to an edge source changes nothing.
- R8: A configuration write that unmasks a level source whose line is high delivers it.
- R9: After reset the output is idle, every source is masked (priority and saved priority 0xFF), and all status bits are clear.
- R10: While dlv_valid is high and dlv_ready is low, the output fields hold steady. When several sources wait, the lowest index goes first.
- R11: A reject or EOI whose number lies outside OFFSET to OFFSET+NSRC-1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Interrupt request lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Source index being configured |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved_prio | input | 8 | New saved priority |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Start a resend scan |
| dlv_valid | output | 1 | Delivery record present |
| dlv_ready | input | 1 | Receiver accepts the delivery |
| dlv_server | output | SRV_W | Target server of the delivery |
| dlv_num | output | NUM_W | Global number of the delivery |
| dlv_prio | output | 8 | Priority of the delivery |

## Verification
The embedded checks assume a well-behaved receiver. A reject or EOI names only a number that was actually handed out, and only after its handshake. That is why a queued level source is always marked in flight, and why the masked-pending flag is only ever seen with priority 0xFF. The directed scenarios keep to this: every reject and EOI is issued after the bench has observed the matching delivery, and the lines change only away from the clock edge. Out-of-range rejects are the one deliberate exception. Their numbers alias onto a live index after truncation, so only the range guard keeps them from changing state.

// File: rtl/isc_pkg.sv
package isc_pkg;

    parameter int SRV_W  = 4;
    parameter int NUM_W  = 16;
    parameter int PRIO_W = 8;

    typedef logic [SRV_W-1:0]  srv_t;
    typedef logic [NUM_W-1:0]  gnum_t;
    typedef logic [PRIO_W-1:0] prio_t;

    localparam prio_t PRIO_MASKED = '1;

    typedef struct packed {
        srv_t  server;
        prio_t prio;
        prio_t saved;
        logic  asserted;
        logic  sent;
        logic  rejected;
        logic  mpend;
        logic  req;
    } src_state_t;

    typedef struct packed {
        srv_t  server;
        gnum_t num;
        prio_t prio;
    } dlv_t;

    function automatic src_state_t reset_state();
        src_state_t r;
        r          = '0;
        r.prio     = PRIO_MASKED;
        r.saved    = PRIO_MASKED;
        return r;
    endfunction

    function automatic logic in_window(gnum_t num, int base, int n);
        return (int'(num) >= base) && (int'(num) < base + n);
    endfunction

endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot
    import isc_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_lvl,
    input  logic       cfg_hit,
    input  srv_t       cfg_srv,
    input  prio_t      cfg_prio,
    input  prio_t      cfg_saved,
    input  logic       rej_hit,
    input  logic       eoi_hit,
    input  logic       scan_hit,
    input  logic       grant,
    output src_state_t st
);

    src_state_t s_q, s_d;
    logic       trig;

    always_comb begin
        s_d  = s_q;
        trig = 1'b0;
        if (grant) s_d.req = 1'b0;
        if (rej_hit) begin
            if (IS_LEVEL) s_d.sent     = 1'b0;
            else          s_d.rejected = 1'b1;
        end
        if (eoi_hit && IS_LEVEL) s_d.sent = 1'b0;
        if (cfg_hit) begin
            s_d.server = cfg_srv;
            s_d.prio   = cfg_prio;
            s_d.saved  = cfg_saved;
            if (IS_LEVEL) begin
                trig = 1'b1;
            end else if (s_d.mpend && cfg_prio != PRIO_MASKED) begin
                s_d.mpend = 1'b0;
                s_d.req   = 1'b1;
            end
        end
        if (in_lvl != s_q.asserted) begin
            s_d.asserted = in_lvl;
            if (IS_LEVEL) begin
                trig = 1'b1;
            end else if (in_lvl) begin
                if (s_d.prio == PRIO_MASKED) s_d.mpend = 1'b1;
                else                         s_d.req   = 1'b1;
            end
        end
        if (scan_hit) begin
            if (IS_LEVEL) begin
                trig = 1'b1;
            end else if (s_d.rejected) begin
                s_d.rejected = 1'b0;
                if (s_d.prio != PRIO_MASKED) s_d.req = 1'b1;
            end
        end
        if (IS_LEVEL && trig && s_d.prio != PRIO_MASKED && s_d.asserted && !s_d.sent) begin
            s_d.sent = 1'b1;
            s_d.req  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= reset_state();
        else     s_q <= s_d;
    end

    assign st = s_q;

    // R3
    mpend_masked_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.mpend |-> (s_q.prio == PRIO_MASKED));

    generate
        if (IS_LEVEL) begin : g_lvl_chk
            // R4
            lvl_inflight_chk: assert property (@(posedge clk) disable iff (rst)
                s_q.req |-> s_q.sent);
        end
    endgenerate

endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          active,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == LAST) active <= 1'b0;
            else             idx    <= idx + 1'b1;
        end
    end

    // R6
    scan_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !start && idx != LAST) |=> (active && idx == $past(idx) + 1'b1));

endmodule

// File: rtl/isc_arb.sv
module isc_arb
    import isc_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  dlv_t         cand [N],
    input  logic         ready,
    output logic         valid,
    output dlv_t         dlv,
    output logic [N-1:0] grant
);

    logic [IW-1:0] pick, sel;
    logic          any;

    always_comb begin
        pick = '0;
        any  = |req;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) pick = IW'(k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            sel   <= '0;
            dlv   <= '0;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end else if (!valid && any) begin
            valid <= 1'b1;
            sel   <= pick;
            dlv   <= cand[pick];
        end
    end

    assign grant = (valid && ready) ? ({{(N-1){1'b0}}, 1'b1} << sel) : '0;

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(dlv)));

endmodule

// File: rtl/isc_source_ctl.sv
module isc_source_ctl
    import isc_pkg::*;
#(
    parameter int             NSRC      = 16,
    parameter int             OFFSET    = 256,
    parameter logic [NSRC-1:0] LEVEL_MAP = 16'hFF00,
    localparam int            IW        = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_in,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_idx,
    input  logic [SRV_W-1:0] cfg_server,
    input  logic [7:0]       cfg_prio,
    input  logic [7:0]       cfg_saved_prio,
    input  logic             rej_valid,
    input  logic [NUM_W-1:0] rej_num,
    input  logic             eoi_valid,
    input  logic [NUM_W-1:0] eoi_num,
    input  logic             resend_req,
    output logic             dlv_valid,
    input  logic             dlv_ready,
    output logic [SRV_W-1:0] dlv_server,
    output logic [NUM_W-1:0] dlv_num,
    output logic [7:0]       dlv_prio
);

    localparam gnum_t BASE = gnum_t'(OFFSET);

    src_state_t       st    [NSRC];
    dlv_t             cand  [NSRC];
    logic [NSRC-1:0]  req_vec, grant_vec;
    logic             scan_on;
    logic [IW-1:0]    scan_idx;
    logic             rej_in, eoi_in;
    logic [IW-1:0]    rej_idx, eoi_idx;
    gnum_t            rej_rel, eoi_rel;
    dlv_t             out_rec;

    assign rej_in  = rej_valid && in_window(rej_num, OFFSET, NSRC);
    assign eoi_in  = eoi_valid && in_window(eoi_num, OFFSET, NSRC);
    assign rej_rel = rej_num - BASE;
    assign eoi_rel = eoi_num - BASE;
    assign rej_idx = rej_rel[IW-1:0];
    assign eoi_idx = eoi_rel[IW-1:0];

    isc_resend_scan #(.N(NSRC), .IW(IW)) u_scan (
        .clk    (clk),
        .rst    (rst),
        .start  (resend_req),
        .active (scan_on),
        .idx    (scan_idx)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            isc_src_slot #(.IS_LEVEL(LEVEL_MAP[i])) u_slot (
                .clk       (clk),
                .rst       (rst),
                .in_lvl    (src_in[i]),
                .cfg_hit   (cfg_we && cfg_idx == IW'(i)),
                .cfg_srv   (cfg_server),
                .cfg_prio  (cfg_prio),
                .cfg_saved (cfg_saved_prio),
                .rej_hit   (rej_in && rej_idx == IW'(i)),
                .eoi_hit   (eoi_in && eoi_idx == IW'(i)),
                .scan_hit  (scan_on && scan_idx == IW'(i)),
                .grant     (grant_vec[i]),
                .st        (st[i])
            );
            assign req_vec[i]     = st[i].req;
            assign cand[i].server = st[i].server;
            assign cand[i].num    = BASE + gnum_t'(i);
            assign cand[i].prio   = st[i].prio;
        end
    endgenerate

    isc_arb #(.N(NSRC), .IW(IW)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (req_vec),
        .cand  (cand),
        .ready (dlv_ready),
        .valid (dlv_valid),
        .dlv   (out_rec),
        .grant (grant_vec)
    );

    assign dlv_server = out_rec.server;
    assign dlv_num    = out_rec.num;
    assign dlv_prio   = out_rec.prio;

    // R2
    num_range_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid |-> in_window(dlv_num, OFFSET, NSRC));

endmodule

// File: tb/isc_source_ctl_tb.sv
module isc_source_ctl_tb;
    import isc_pkg::*;

    localparam int NSRC = 16;
    localparam int OFF  = 256;
    localparam int IW   = $clog2(NSRC);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NSRC-1:0]  src_in = '0;
    logic             cfg_we = 1'b0;
    logic [IW-1:0]    cfg_idx = '0;
    logic [SRV_W-1:0] cfg_server = '0;
    logic [7:0]       cfg_prio = '0;
    logic [7:0]       cfg_saved_prio = '0;
    logic             rej_valid = 1'b0;
    logic [NUM_W-1:0] rej_num = '0;
    logic             eoi_valid = 1'b0;
    logic [NUM_W-1:0] eoi_num = '0;
    logic             resend_req = 1'b0;
    logic             dlv_valid;
    logic             dlv_ready = 1'b1;
    logic [SRV_W-1:0] dlv_server;
    logic [NUM_W-1:0] dlv_num;
    logic [7:0]       dlv_prio;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    isc_source_ctl #(.NSRC(NSRC), .OFFSET(OFF), .LEVEL_MAP(16'hFF00)) u_dut (
        .clk(clk), .rst(rst), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .cfg_saved_prio(cfg_saved_prio),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_server(dlv_server), .dlv_num(dlv_num), .dlv_prio(dlv_prio)
    );

    task automatic check(string tag, logic ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_dlv(string tag, int srv, int num, int prio);
        bit got = 0;
        for (int c = 0; c < 24 && !got; c++) begin
            @(negedge clk);
            if (dlv_valid) begin
                got = 1;
                check(tag, dlv_num == NUM_W'(num), "delivery number", int'(dlv_num), num);
                check(tag, dlv_server == SRV_W'(srv), "delivery server", int'(dlv_server), srv);
                check(tag, dlv_prio == 8'(prio), "delivery priority", int'(dlv_prio), prio);
            end
        end
        if (!got) check(tag, 1'b0, "delivery seen", 0, 1);
    endtask

    task automatic expect_none(string tag, int cycles);
        bit seen = 0;
        int num = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (dlv_valid && !seen) begin
                seen = 1;
                num  = int'(dlv_num);
            end
        end
        check(tag, !seen, "unexpected delivery number", num, 0);
    endtask

    task automatic cfg(int idx, int srv, int prio);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_server = SRV_W'(srv);
        cfg_prio = 8'(prio); cfg_saved_prio = 8'(prio);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(int idx);
        @(negedge clk); src_in[idx] = 1'b1;
        @(negedge clk); src_in[idx] = 1'b0;
    endtask

    task automatic reject(int num);
        @(negedge clk); rej_valid = 1'b1; rej_num = NUM_W'(num);
        @(negedge clk); rej_valid = 1'b0;
    endtask

    task automatic eoi(int num);
        @(negedge clk); eoi_valid = 1'b1; eoi_num = NUM_W'(num);
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic resend();
        @(negedge clk); resend_req = 1'b1;
        @(negedge clk); resend_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9", dlv_valid == 1'b0, "valid after reset", int'(dlv_valid), 0);
        pulse(1);
        resend();
        expect_none("R9_R1", 24);
    endtask

    task automatic t_edge_masked();
        pulse(2);
        expect_none("R1", 6);
        cfg(2, 3, 4);
        expect_dlv("R3", 3, OFF + 2, 4);
        expect_none("R3_once", 6);
    endtask

    task automatic t_edge_basic();
        cfg(5, 1, 7);
        pulse(5);
        expect_dlv("R2", 1, OFF + 5, 7);
        pulse(5);
        expect_dlv("R2_again", 1, OFF + 5, 7);
    endtask

    task automatic t_edge_reject();
        reject(OFF + 5);
        eoi(OFF + 5);
        resend();
        expect_dlv("R5_R7", 1, OFF + 5, 7);
        resend();
        expect_none("R5_once", 24);
    endtask

    task automatic t_out_of_range();
        cfg(0, 6, 2);
        pulse(0);
        expect_dlv("R2_src0", 6, OFF, 2);
        reject(OFF + NSRC);
        reject(OFF - NSRC);
        resend();
        expect_none("R11", 24);
    endtask

    task automatic t_level();
        cfg(9, 2, 3);
        @(negedge clk); src_in[9] = 1'b1;
        expect_dlv("R4", 2, OFF + 9, 3);
        resend();
        expect_none("R4_inflight", 24);
        eoi(OFF + 9);
        expect_none("R7_noauto", 8);
        resend();
        expect_dlv("R7", 2, OFF + 9, 3);
        reject(OFF + 9);
        resend();
        expect_dlv("R5_level", 2, OFF + 9, 3);
        @(negedge clk); src_in[9] = 1'b0;
        eoi(OFF + 9);
        resend();
        expect_none("R4_low", 24);
    endtask

    task automatic t_level_masked();
        @(negedge clk); src_in[10] = 1'b1;
        expect_none("R1_level", 6);
        cfg(10, 5, 6);
        expect_dlv("R8", 5, OFF + 10, 6);
        @(negedge clk); src_in[10] = 1'b0;
        eoi(OFF + 10);
    endtask

    task automatic t_backpressure();
        logic [NUM_W-1:0] first_num;
        cfg(4, 2, 1);
        cfg(6, 5, 1);
        @(negedge clk); dlv_ready = 1'b0; src_in[4] = 1'b1; src_in[6] = 1'b1;
        @(negedge clk); src_in[4] = 1'b0; src_in[6] = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", dlv_valid == 1'b1, "valid under stall", int'(dlv_valid), 1);
        check("R10", dlv_num == NUM_W'(OFF + 4), "lowest index first", int'(dlv_num), OFF + 4);
        first_num = dlv_num;
        repeat (4) @(negedge clk);
        check("R10", dlv_valid && dlv_num == first_num && dlv_server == 2,
              "held record number", int'(dlv_num), int'(first_num));
        dlv_ready = 1'b1;
        expect_dlv("R10_next", 5, OFF + 6, 1);
    endtask

    task automatic t_scan_restart();
        cfg(7, 3, 9);
        pulse(7);
        expect_dlv("R6_prep", 3, OFF + 7, 9);
        reject(OFF + 7);
        @(negedge clk); resend_req = 1'b1;
        repeat (5) @(negedge clk);
        resend_req = 1'b0;
        expect_dlv("R6", 3, OFF + 7, 9);
        expect_none("R6_once", 24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_edge_masked();
        t_edge_basic();
        t_edge_reject();
        t_out_of_range();
        t_level();
        t_level_masked();
        t_backpressure();
        t_scan_restart();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule